// File: doc/BRIEF.md
# UART FIFO Control and Status Slice

This block manages the byte queues of a 16550-style serial port. It holds one queue for the transmit direction and one for the receive direction. Each queue has DEPTH entries of DATA_W bits and uses first-in, first-out order. A single control register write does several things at once:

- it selects between queued operation and one-byte holding registers;
- it can flush either queue;
- it selects one of two DMA signalling modes;
- it picks a threshold for each direction.

The block does not contain the serial shifters. The transmit shifter pops bytes from this block, and the receive shifter pushes bytes into it. The shifters report whether they are busy, and the receive side can also flag an external overrun.

From its queues and configuration the block builds the following outputs:

- a threshold flag for each direction;
- the receive-side line status bits;
- the interrupt-identification byte, which carries a pending bit and the queue mode;
- a 32-bit vendor status word, which holds the idle bits for both directions and the live transmit occupancy.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After synchronous reset, `cfg_rdata`=0x00, `lsr`=0x200, `iir`=0x00, `tx_trig`=1, `rx_trig`=0, and `vstat`=0x00000003 while both busy inputs are low.
- R2: A write on `cfg_wdata` stores the following fields, and `cfg_rdata` returns them the next cycle: bit 0 enables the queues, bit 3 selects the DMA mode (also driven on `dma_mode`), bits 5:4 hold the transmit threshold code and bits 7:6 hold the receive threshold code. Bits 2:1 always read back as 0.
- R3: With queues enabled, each queue holds up to DEPTH bytes in order of arrival. The oldest byte is presented on `tx_rdata`/`rx_rdata` and is removed by a pop. A push into a full queue is dropped, and a pop from an empty queue has no effect.
- R4: Writing bit 1 empties the receive queue and writing bit 2 empties the transmit queue, with the count at 0 on the next cycle. A push in the same cycle is discarded. The other queue and the busy inputs are not affected.
- R5: A write that changes bit 0 empties both queues.
- R6: With queues enabled, `tx_trig`=1 while the transmit count is at or below the level for its code: 0→DEPTH, 1→DEPTH/2, 2→DEPTH/4, 3→1.
- R7: With queues enabled, `rx_trig`=1 while the receive count is at or above the level for its code: 0→1, 1→DEPTH/4, 2→DEPTH/2, 3→DEPTH.
- R8: With queues disabled, each direction holds at most one byte and further pushes are dropped. In this mode `rx_trig`=1 when that byte is present and `tx_trig`=1 when it is absent.
- R9: `lsr[1]` sets on `rx_ovr_in`, or on a receive push that is dropped because the queue is full. It clears after a cycle with `lsr_rd`=1, unless a set occurs in that same cycle, in which case the set wins.
- R10: `lsr[0]`=1 when the receive queue is non-empty and `lsr[9]`=1 when it is empty. All other `lsr` bits are 0.
- R11: `iir[0]`=0 when `tx_trig` or `rx_trig` is 1, else 1. `iir[7:6]`=01 with queues enabled and 00 otherwise. All other bits are 0.
- R12: `vstat[0]`=1 when the transmit queue is empty and `tx_busy`=0. `vstat[1]`=1 when the receive queue is empty and `rx_busy`=0. `vstat[29:24]` holds the transmit count. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register readback |
| dma_mode | output | 1 | Selected DMA mode |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | DATA_W | Byte to push into the transmit queue |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_rdata | output | DATA_W | Transmit queue head |
| tx_busy | input | 1 | Transmit shifter active |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_wdata | input | DATA_W | Received byte |
| rx_pop | input | 1 | Remove the receive queue head |
| rx_rdata | output | DATA_W | Receive queue head |
| rx_busy | input | 1 | Receive shifter active |
| rx_ovr_in | input | 1 | External overrun indication |
| lsr_rd | input | 1 | Line status read strobe |
| lsr | output | 10 | Line status bits |
| iir | output | 8 | Interrupt identification byte |
| vstat | output | 32 | Vendor status word |
| tx_trig | output | 1 | Transmit threshold flag |
| rx_trig | output | 1 | Receive threshold flag |

## Verification
The hardest states to reach are the threshold boundaries at full depth and the overrun caused by a push into a full receive queue. These are only reachable by filling a queue entry by entry. The bench therefore sweeps every threshold code in both directions. At each code it pushes from empty up to one entry past full, then drains to empty, and compares both flags against levels computed from the codes at every count. It also drives the overrun set and the status read in the same cycle to check which one wins.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Stored control fields; the flush bits are strobes and are not kept
  typedef struct packed {
    logic [1:0] rx_lvl;
    logic [1:0] tx_lvl;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_CLR_RX  = 1;
  localparam int CFG_CLR_TX  = 2;
  localparam int CFG_DMA_BIT = 3;
  localparam int STAT_CNT_LO = 24;
  localparam int STAT_CNT_W  = 6;
endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic [7:0] wdata,
  output fifo_cfg_t cfg,
  output logic      flush_rx,
  output logic      flush_tx
);
  logic mode_chg;

  assign mode_chg = wr && (wdata[CFG_EN_BIT] != cfg.en);
  assign flush_rx = (wr && wdata[CFG_CLR_RX]) || mode_chg;
  assign flush_tx = (wr && wdata[CFG_CLR_TX]) || mode_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.rx_lvl <= wdata[7:6];
      cfg.tx_lvl <= wdata[5:4];
      cfg.dma    <= wdata[CFG_DMA_BIT];
      cfg.en     <= wdata[CFG_EN_BIT];
    end
  end
endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         single,
  input  logic                         push,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         pop,
  output logic [DATA_W-1:0]            rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, do_push, do_pop;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && (count != '0) && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              dma_mode,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              tx_busy,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              rx_busy,
  input  logic              rx_ovr_in,
  input  logic              lsr_rd,
  output logic [9:0]        lsr,
  output logic [7:0]        iir,
  output logic [31:0]       vstat,
  output logic              tx_trig,
  output logic              rx_trig
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] LV_D = CW'(DEPTH);
  localparam logic [CW-1:0] LV_H = CW'(DEPTH/2);
  localparam logic [CW-1:0] LV_Q = CW'(DEPTH/4);
  localparam logic [CW-1:0] LV_1 = CW'(1);

  fifo_cfg_t     cfg;
  logic          flush_rx, flush_tx;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_lim, rx_lim;
  logic          rx_full, ovr;

  uart_fifo_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .cfg(cfg), .flush_rx(flush_rx), .flush_tx(flush_tx)
  );

  uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx), .single(!cfg.en),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_cnt)
  );

  uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx), .single(!cfg.en),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_cnt)
  );

  assign rx_full = cfg.en ? (rx_cnt == LV_D) : (rx_cnt != '0);

  // Overrun: a set in the read cycle wins over the clear
  always_ff @(posedge clk) begin
    if (rst)                                          ovr <= 1'b0;
    else if (rx_ovr_in || (rx_push && rx_full && !flush_rx)) ovr <= 1'b1;
    else if (lsr_rd)                                  ovr <= 1'b0;
  end

  // Threshold levels: the two directions order their codes oppositely
  always_comb begin
    case (cfg.tx_lvl)
      2'd0:    tx_lim = LV_D;
      2'd1:    tx_lim = LV_H;
      2'd2:    tx_lim = LV_Q;
      default: tx_lim = LV_1;
    endcase
    case (cfg.rx_lvl)
      2'd0:    rx_lim = LV_1;
      2'd1:    rx_lim = LV_Q;
      2'd2:    rx_lim = LV_H;
      default: rx_lim = LV_D;
    endcase
  end

  assign tx_trig = cfg.en ? (tx_cnt <= tx_lim) : (tx_cnt == '0);
  assign rx_trig = cfg.en ? (rx_cnt >= rx_lim) : (rx_cnt != '0);

  assign cfg_rdata = {cfg.rx_lvl, cfg.tx_lvl, cfg.dma, 2'b00, cfg.en};
  assign dma_mode  = cfg.dma;
  assign lsr       = {(rx_cnt == '0), 7'd0, ovr, (rx_cnt != '0)};
  assign iir       = {1'b0, cfg.en, 5'd0, !(tx_trig || rx_trig)};

  always_comb begin
    vstat = '0;
    vstat[0] = (tx_cnt == '0) && !tx_busy;
    vstat[1] = (rx_cnt == '0) && !rx_busy;
    vstat[STAT_CNT_LO +: STAT_CNT_W] = STAT_CNT_W'(tx_cnt);
  end
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr,
  input logic       clr_rx_req,
  input logic       clr_tx_req,
  input logic [1:0] rd_clr_bits,
  input logic       fifo_on,
  input logic       ovr_in,
  input logic       rx_push,
  input logic       lsr_rd,
  input logic       lsr_rdy,
  input logic       lsr_ovr,
  input logic       lsr_empty,
  input logic       iir_n,
  input logic [1:0] iir_mode,
  input logic [5:0] tx_cnt,
  input logic       tx_trig,
  input logic       rx_trig
);
  assert_clr_selfreset_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> rd_clr_bits == 2'b00);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    32'(tx_cnt) <= DEPTH);
  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_rx_req |=> lsr_empty);
  assert_tx_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_tx_req |=> tx_cnt == 6'd0);
  assert_single_cap_R8: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |-> tx_cnt <= 6'd1);
  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (rst)
    ovr_in |=> lsr_ovr);
  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ovr_in && !rx_push) |=> !lsr_ovr);
  assert_lsr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    lsr_rdy != lsr_empty);
  assert_iir_pend_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_trig || rx_trig) |-> !iir_n);
  assert_iir_mode_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_on |-> iir_mode == 2'b01);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
  .clr_rx_req(cfg_wr && cfg_wdata[1]), .clr_tx_req(cfg_wr && cfg_wdata[2]),
  .rd_clr_bits(cfg_rdata[2:1]), .fifo_on(cfg_rdata[0]),
  .ovr_in(rx_ovr_in), .rx_push(rx_push), .lsr_rd(lsr_rd),
  .lsr_rdy(lsr[0]), .lsr_ovr(lsr[1]), .lsr_empty(lsr[9]),
  .iir_n(iir[0]), .iir_mode(iir[7:6]), .tx_cnt(vstat[29:24]),
  .tx_trig(tx_trig), .rx_trig(rx_trig)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_wr, tx_push, tx_pop, tx_busy, rx_push, rx_pop, rx_busy, rx_ovr_in, lsr_rd;
  logic [7:0] cfg_wdata, cfg_rdata, iir;
  logic [DW-1:0] tx_wdata, tx_rdata, rx_wdata, rx_rdata;
  logic dma_mode, tx_trig, rx_trig;
  logic [9:0] lsr;
  logic [31:0] vstat;

  uart_fifo_ctl #(.DATA_W(DW), .DEPTH(DEPTH)) u_uart_fifo_ctl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dma_mode(dma_mode), .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_busy(tx_busy), .rx_push(rx_push), .rx_wdata(rx_wdata),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_busy(rx_busy), .rx_ovr_in(rx_ovr_in),
    .lsr_rd(lsr_rd), .lsr(lsr), .iir(iir), .vstat(vstat), .tx_trig(tx_trig), .rx_trig(rx_trig)
  );

  int errs = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic cfg(input logic [7:0] v); cfg_wr = 1; cfg_wdata = v; tick(); cfg_wr = 0; endtask
  task automatic txpush(input logic [7:0] b); tx_push = 1; tx_wdata = b; tick(); tx_push = 0; endtask
  task automatic rxpush(input logic [7:0] b); rx_push = 1; rx_wdata = b; tick(); rx_push = 0; endtask
  task automatic txpop(); tx_pop = 1; tick(); tx_pop = 0; endtask
  task automatic rxpop(); rx_pop = 1; tick(); rx_pop = 0; endtask
  task automatic lsrread(); lsr_rd = 1; tick(); lsr_rd = 0; endtask

  function automatic int txlvl(input int c);
    return (c == 0) ? DEPTH : (c == 1) ? DEPTH/2 : (c == 2) ? DEPTH/4 : 1;
  endfunction
  function automatic int rxlvl(input int c);
    return (c == 0) ? 1 : (c == 1) ? DEPTH/4 : (c == 2) ? DEPTH/2 : DEPTH;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1; cfg_wr = 0; cfg_wdata = 0; tx_push = 0; tx_pop = 0; tx_busy = 0; tx_wdata = 0;
    rx_push = 0; rx_pop = 0; rx_busy = 0; rx_wdata = 0; rx_ovr_in = 0; lsr_rd = 0;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check("R1 cfg", cfg_rdata, 0);
    check("R1 lsr", lsr, 10'h200);
    check("R1 iir", iir, 0);
    check("R1 vstat", vstat, 3);
    check("R1 tx_trig", tx_trig, 1);
    check("R1 rx_trig", rx_trig, 0);

    // R2 readback sweep over all write values
    for (int v = 0; v < 256; v++) begin
      cfg(8'(v));
      check("R2 readback", cfg_rdata, v & 8'hF9);
      check("R2 dma", dma_mode, (v >> 3) & 1);
    end

    // R3 R6 R7 R9 R10 R11 R12 per threshold code
    for (int c = 0; c < 4; c++) begin
      int rc;
      rc = 3 - c;
      cfg(8'((rc << 6) | (c << 4) | 7));
      check("R11 mode", iir[7:6], 2'b01);
      for (int i = 0; i <= DEPTH; i++) begin
        int n;
        n = (i > DEPTH) ? DEPTH : i;
        check("R6 tx_trig", tx_trig, (n <= txlvl(c)) ? 1 : 0);
        check("R12 tx count", vstat[29:24], n);
        check("R11 pend", iir[0], (n <= txlvl(c)) ? 0 : 1);
        txpush(8'(8'h30 + i));
      end
      check("R3 tx full cap", vstat[29:24], DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        check("R3 tx order", tx_rdata, 8'(8'h30 + i));
        txpop();
        check("R6 tx_trig drain", tx_trig, ((DEPTH - 1 - i) <= txlvl(c)) ? 1 : 0);
      end
      check("R12 tx idle", vstat[0], 1);
      for (int i = 0; i <= DEPTH; i++) begin
        check("R7 rx_trig", rx_trig, (i >= rxlvl(rc)) ? 1 : 0);
        check("R10 lsr", lsr, (i == 0) ? 10'h200 : 10'h001);
        check("R12 rx idle", vstat[1], (i == 0) ? 1 : 0);
        rxpush(8'(8'hA0 + i + c));
      end
      check("R9 overflow sets", lsr, 10'h003);
      lsrread();
      check("R9 read clears", lsr, 10'h001);
      for (int i = 0; i < DEPTH; i++) begin
        check("R3 rx order", rx_rdata, 8'(8'hA0 + i + c));
        rxpop();
        check("R7 rx_trig drain", rx_trig, ((DEPTH - 1 - i) >= rxlvl(rc)) ? 1 : 0);
      end
      rxpop();
      check("R3 empty pop ignored", lsr, 10'h200);
    end

    // R4 clear isolation
    cfg(8'h07);
    for (int i = 0; i < 3; i++) txpush(8'(i));
    for (int i = 0; i < 5; i++) rxpush(8'(8'h50 + i));
    cfg(8'h03);
    check("R4 rx cleared", lsr, 10'h200);
    check("R4 tx kept", vstat[29:24], 3);
    check("R4 tx head kept", tx_rdata, 0);
    tx_busy = 1;
    cfg(8'h05);
    check("R4 tx cleared", vstat[29:24], 0);
    check("R4 busy untouched", vstat[0], 0);
    tx_busy = 0; rx_busy = 1; #1;
    check("R12 idle bits", vstat[1:0], 2'b01);
    rx_busy = 0;
    rx_push = 1; rx_wdata = 8'h77; cfg_wr = 1; cfg_wdata = 8'h03; tick();
    rx_push = 0; cfg_wr = 0;
    check("R4 push during clear dropped", lsr, 10'h200);

    // R5 enable change flushes both
    txpush(8'h01); txpush(8'h02); rxpush(8'h03);
    cfg(8'h00);
    check("R5 tx flushed", vstat[29:24], 0);
    check("R5 rx flushed", lsr, 10'h200);
    check("R11 no-fifo mode", iir[7:6], 2'b00);

    // R8 holding-register mode
    rxpush(8'h11);
    check("R8 rx_trig", rx_trig, 1);
    check("R8 lsr", lsr, 10'h001);
    rxpush(8'h22);
    check("R8 second rx dropped ovr", lsr, 10'h003);
    check("R8 rx head", rx_rdata, 8'h11);
    rxpop();
    check("R8 rx empty", rx_trig, 0);
    lsrread();
    check("R8 tx_trig empty", tx_trig, 1);
    txpush(8'h33);
    check("R8 tx_trig held", tx_trig, 0);
    txpush(8'h44);
    check("R8 tx cap", vstat[29:24], 1);
    check("R8 tx head", tx_rdata, 8'h33);
    txpop();
    check("R8 tx empty", tx_trig, 1);

    // R9 set/clear priority
    rx_ovr_in = 1; tick(); rx_ovr_in = 0;
    check("R9 external set", lsr[1], 1);
    rx_ovr_in = 1; lsr_rd = 1; tick(); rx_ovr_in = 0; lsr_rd = 0;
    check("R9 set wins", lsr[1], 1);
    lsrread();
    check("R9 cleared", lsr[1], 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule